// File: doc/BRIEF.md
# Per-PC Prefetch Throttle

This block sits between a set of hardware prefetchers and the memory request path. Each prefetch request arrives tagged with the load PC that triggered it and the ID of the prefetcher that made it. The block keeps a small state machine for every pair of table slot and prefetcher. The state decides what happens to the request: it goes out with a high degree, goes out with a low degree, or is dropped.

For each pair, the block counts the prefetches it let through and the useful-prefetch reports it received during the current epoch. At each epoch tick it grades every pair on the accuracy useful/issued and moves the pair to aggressive, conservative or blocked. The comparison uses integer products only, so no divider is needed. A blocked pair is allowed to probe again after it has sat out two whole epochs. Because throttling is per PC and per prefetcher, one noisy load cannot shut off a prefetcher that works well for other loads.

Top module: `pc_pf_throttle`

## Requirements
- R1: After reset every pair is conservative, `out_valid_o` is 0 and `out_degree_o` is 0.
- R2: A request is answered exactly one clock later. When passed, `out_pc_o` and `out_pf_o` repeat the request's PC and prefetcher ID. `out_valid_o` is never 1 without a request in the previous cycle.
- R3: The state of the pair (low 6 PC bits, prefetcher ID) sets the output. Aggressive gives `out_valid_o`=1 with `out_degree_o`=4. Conservative gives `out_valid_o`=1 with degree 1. Blocked gives `out_valid_o`=0 with degree 0. No other pair is affected.
- R4: The issued count rises by one for each request passed for the pair. The useful count rises by one for each feedback pulse on the pair. Both counts saturate at 63.
- R5: At a tick, a non-blocked pair with issued>0 and 4*useful >= 3*issued becomes aggressive.
- R6: At a tick, a non-blocked pair with issued>0 and issued <= 4*useful < 3*issued becomes conservative.
- R7: At a tick, a non-blocked pair with issued>0 and 4*useful < issued becomes blocked.
- R8: At a tick, a non-blocked pair with issued=0 keeps its state.
- R9: A pair that becomes blocked returns to conservative on the second tick after the one that blocked it. Blocked never moves straight to aggressive.
- R10: Both counts restart at each tick. Events in the tick cycle count toward the new epoch. A request in the tick cycle is filtered by the state from before the tick.
- R11: PCs that differ only above bit 5 share one pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| epoch_tick_i | input | 1 | End-of-epoch pulse |
| req_valid_i | input | 1 | Prefetch request valid |
| req_pc_i | input | 32 | PC of the triggering load |
| req_pf_i | input | 1 | ID of the requesting prefetcher |
| fb_valid_i | input | 1 | Useful-prefetch report valid |
| fb_pc_i | input | 32 | PC the useful prefetch belongs to |
| fb_pf_i | input | 1 | Prefetcher the useful prefetch came from |
| out_valid_o | output | 1 | Filtered request valid |
| out_pc_o | output | 32 | Filtered request PC |
| out_pf_o | output | 1 | Filtered request prefetcher ID |
| out_degree_o | output | 3 | Allowed degree (4, 1, or 0 when idle) |

## Verification
The bench aims at each accuracy threshold with directed ratios: 3 of 4 must give aggressive, 2 of 4 conservative and 0 of 4 blocked. A design that divided with truncation, or swapped strict and non-strict compares, would land on the wrong degree. It pushes 64 requests into one epoch; a wrapping counter would read as an idle epoch and wrongly keep the aggressive state. It checks that an idle epoch leaves the state alone, that recovery from blocked takes exactly two ticks, and that aliased PCs share one pair. Seeded random traffic, with ticks that fall on busy cycles, checks the tick-cycle ordering against a reference model in the bench.

// File: rtl/pft_pkg.sv
package pft_pkg;
  typedef enum logic [1:0] {
    ST_BLK = 2'd0,
    ST_CON = 2'd1,
    ST_AGG = 2'd2
  } pf_state_e;
endpackage

// File: rtl/pft_grade.sv
module pft_grade
  import pft_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic [CNT_W-1:0] iss_i,
  input  logic [CNT_W-1:0] use_i,
  input  pf_state_e        cur_i,
  input  logic             bwait_i,
  output pf_state_e        nxt_o,
  output logic             bwait_o
);
  localparam int AW = CNT_W + 2;

  logic [AW-1:0] use_x4, iss_x3, iss_x1;

  assign use_x4 = {use_i, 2'b00};
  assign iss_x1 = AW'(iss_i);
  assign iss_x3 = (iss_x1 << 1) + iss_x1;

  always_comb begin
    nxt_o   = cur_i;
    bwait_o = 1'b0;
    if (cur_i == ST_BLK) begin
      if (bwait_i) nxt_o = ST_CON;
      else         bwait_o = 1'b1;
    end else if (iss_i != '0) begin
      if (use_x4 >= iss_x3)      nxt_o = ST_AGG;
      else if (use_x4 >= iss_x1) nxt_o = ST_CON;
      else                       nxt_o = ST_BLK;
    end
  end
endmodule

// File: rtl/pft_entry.sv
module pft_entry
  import pft_pkg::*;
#(
  parameter int CNT_W = 6
) (
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      tick_i,
  input  logic      issue_i,
  input  logic      useful_i,
  output pf_state_e state_o
);
  localparam logic [CNT_W-1:0] CMAX = '1;

  logic [CNT_W-1:0] iss_q, use_q;
  logic             bw_q, bw_d;
  pf_state_e        st_q, st_d;

  pft_grade #(.CNT_W(CNT_W)) u_grade (
    .iss_i  (iss_q),
    .use_i  (use_q),
    .cur_i  (st_q),
    .bwait_i(bw_q),
    .nxt_o  (st_d),
    .bwait_o(bw_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_CON;
      bw_q  <= 1'b0;
      iss_q <= '0;
      use_q <= '0;
    end else if (tick_i) begin
      st_q  <= st_d;
      bw_q  <= bw_d;
      iss_q <= CNT_W'(issue_i);
      use_q <= CNT_W'(useful_i);
    end else begin
      iss_q <= iss_q + CNT_W'(issue_i && iss_q != CMAX);
      use_q <= use_q + CNT_W'(useful_i && use_q != CMAX);
    end
  end

  assign state_o = st_q;

  p_cnt_sat_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iss_q == CMAX && !tick_i) |=> iss_q == CMAX);
  p_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (iss_q <= CNT_W'(1) && use_q <= CNT_W'(1)));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && st_q != ST_BLK && iss_q == '0) |=> st_q == $past(st_q));
  p_blk_no_jump_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == ST_BLK |=> st_q != ST_AGG);
endmodule

// File: rtl/pc_pf_throttle.sv
module pc_pf_throttle
  import pft_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int PF_N   = 2,
  parameter int IDX_W  = 6,
  parameter int CNT_W  = 6,
  parameter int DEG_W  = 3,
  parameter int DEG_HI = 4,
  parameter int DEG_LO = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             epoch_tick_i,
  input  logic             req_valid_i,
  input  logic [PC_W-1:0]  req_pc_i,
  input  logic [(PF_N>1 ? $clog2(PF_N) : 1)-1:0] req_pf_i,
  input  logic             fb_valid_i,
  input  logic [PC_W-1:0]  fb_pc_i,
  input  logic [(PF_N>1 ? $clog2(PF_N) : 1)-1:0] fb_pf_i,
  output logic             out_valid_o,
  output logic [PC_W-1:0]  out_pc_o,
  output logic [(PF_N>1 ? $clog2(PF_N) : 1)-1:0] out_pf_o,
  output logic [DEG_W-1:0] out_degree_o
);
  localparam int ENT  = 1 << IDX_W;
  localparam int PF_W = PF_N > 1 ? $clog2(PF_N) : 1;

  logic [IDX_W-1:0] req_idx, fb_idx;
  pf_state_e        st [ENT][PF_N];
  pf_state_e        sel_st;

  assign req_idx = req_pc_i[IDX_W-1:0];
  assign fb_idx  = fb_pc_i[IDX_W-1:0];
  assign sel_st  = st[req_idx][req_pf_i];

  for (genvar e = 0; e < ENT; e++) begin : g_ent
    for (genvar p = 0; p < PF_N; p++) begin : g_pf
      logic hit_req, hit_fb;
      assign hit_req = req_valid_i && req_idx == IDX_W'(e) && req_pf_i == PF_W'(p)
                       && st[e][p] != ST_BLK;
      assign hit_fb  = fb_valid_i && fb_idx == IDX_W'(e) && fb_pf_i == PF_W'(p);
      pft_entry #(.CNT_W(CNT_W)) u_entry (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .tick_i  (epoch_tick_i),
        .issue_i (hit_req),
        .useful_i(hit_fb),
        .state_o (st[e][p])
      );
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o  <= 1'b0;
      out_pc_o     <= '0;
      out_pf_o     <= '0;
      out_degree_o <= '0;
    end else begin
      out_valid_o  <= req_valid_i && sel_st != ST_BLK;
      out_pc_o     <= req_pc_i;
      out_pf_o     <= req_pf_i;
      if (!req_valid_i || sel_st == ST_BLK) out_degree_o <= '0;
      else if (sel_st == ST_AGG)            out_degree_o <= DEG_W'(DEG_HI);
      else                                  out_degree_o <= DEG_W'(DEG_LO);
    end
  end

  p_deg_legal_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_degree_o == DEG_W'(DEG_HI) || out_degree_o == DEG_W'(DEG_LO)));
  p_idle_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !out_valid_o |-> out_degree_o == '0);
  p_no_spont_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> $past(req_valid_i));
  p_pc_echo_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> out_pc_o == $past(req_pc_i));
endmodule

// File: tb/pc_pf_throttle_tb.sv
module pc_pf_throttle_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        epoch_tick_i = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_pc_i = '0;
  logic [0:0]  req_pf_i = '0;
  logic        fb_valid_i = 1'b0;
  logic [31:0] fb_pc_i = '0;
  logic [0:0]  fb_pf_i = '0;
  logic        out_valid_o;
  logic [31:0] out_pc_o;
  logic [0:0]  out_pf_o;
  logic [2:0]  out_degree_o;

  always #5 clk_i = ~clk_i;

  pc_pf_throttle dut_i (.*);

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  // model: 0 blocked, 1 conservative, 2 aggressive
  int mst [64][2];
  int miss[64][2];
  int muse[64][2];
  int mbw [64][2];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_deg(input int s);
    return s == 2 ? 4 : (s == 1 ? 1 : 0);
  endfunction

  function automatic int grade(input int s, input int bw, input int i, input int u);
    if (s == 0) return bw ? 1 : 0;
    if (i == 0) return s;
    if (4 * u >= 3 * i) return 2;
    if (4 * u >= i) return 1;
    return 0;
  endfunction

  task automatic cyc(input bit v, input int pc, input int pf, input bit fv,
                     input int fpc, input int fpf, input bit tk, input string tag);
    int ri, fi, es, ev;
    @(negedge clk_i);
    req_valid_i = v; req_pc_i = pc; req_pf_i = 1'(pf);
    fb_valid_i = fv; fb_pc_i = fpc; fb_pf_i = 1'(fpf);
    epoch_tick_i = tk;
    ri = pc & 63; fi = fpc & 63;
    es = mst[ri][pf];
    ev = v && es != 0;
    if (tk) begin
      for (int e = 0; e < 64; e++)
        for (int p = 0; p < 2; p++) begin
          int ns, nb;
          ns = grade(mst[e][p], mbw[e][p], miss[e][p], muse[e][p]);
          nb = (mst[e][p] == 0 && mbw[e][p] == 0) ? 1 : 0;
          mst[e][p] = ns; mbw[e][p] = nb;
          miss[e][p] = 0; muse[e][p] = 0;
        end
      if (ev) miss[ri][pf] = 1;
      if (fv) muse[fi][fpf] = 1;
    end else begin
      if (ev && miss[ri][pf] < 63) miss[ri][pf]++;
      if (fv && muse[fi][fpf] < 63) muse[fi][fpf]++;
    end
    @(posedge clk_i); #1;
    check(out_valid_o == ev, tag, out_valid_o, ev);
    check(int'(out_degree_o) == (ev ? exp_deg(es) : 0), tag, out_degree_o, ev ? exp_deg(es) : 0);
    if (ev) begin
      check(out_pc_o == pc, tag, out_pc_o, pc);
      check(int'(out_pf_o) == pf, tag, out_pf_o, pf);
    end
  endtask

  // n requests with k useful reports for one pair, then a quiet tick
  task automatic epoch(input int pc, input int pf, input int n, input int k, input string tag);
    for (int j = 0; j < n; j++) cyc(1, pc, pf, j < k, pc, pf, 0, tag);
    cyc(0, 0, 0, 0, 0, 0, 1, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    for (int e = 0; e < 64; e++)
      for (int p = 0; p < 2; p++) begin
        mst[e][p] = 1; miss[e][p] = 0; muse[e][p] = 0; mbw[e][p] = 0;
      end
    repeat (3) @(posedge clk_i);
    #1;
    check(out_valid_o == 0, "R1", out_valid_o, 0);
    check(out_degree_o == 0, "R1", out_degree_o, 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc(0, 0, 0, 0, 0, 0, 0, "R1");
    cyc(1, 5, 0, 0, 0, 0, 0, "R1");              // conservative -> degree 1
    epoch(5, 0, 3, 3, "R5");                    // one already issued: 4 iss, 3 useful
    cyc(1, 5, 0, 0, 0, 0, 0, "R5");              // degree 4
    cyc(1, 5, 1, 0, 0, 0, 0, "R3");              // other prefetcher still conservative
    cyc(1, 5 + 64 * 7, 0, 0, 0, 0, 0, "R11");    // aliased PC shares aggressive state
    epoch(5, 0, 2, 2, "R6");                    // 4 iss, 2 useful -> conservative
    cyc(1, 5, 0, 0, 0, 0, 0, "R6");
    epoch(5, 0, 3, 0, "R7");                    // 4 iss, 0 useful -> blocked
    cyc(1, 5, 0, 0, 0, 0, 0, "R7");              // dropped
    cyc(0, 0, 0, 0, 0, 0, 1, "R9");              // first blocked tick
    cyc(1, 5, 0, 0, 0, 0, 0, "R9");              // still dropped
    cyc(0, 0, 0, 0, 0, 0, 1, "R9");              // second -> conservative
    cyc(1, 5, 0, 0, 0, 0, 0, "R9");
    epoch(9, 1, 4, 4, "R5");
    cyc(0, 0, 0, 0, 0, 0, 1, "R8");              // idle epoch keeps aggressive
    cyc(1, 9, 1, 0, 0, 0, 0, "R8");
    epoch(9, 1, 63, 20, "R4");                  // 64 issued saturates at 63 -> conservative
    cyc(1, 9, 1, 0, 0, 0, 0, "R4");
    cyc(1, 9, 1, 1, 9, 1, 1, "R10");             // tick cycle event counts in new epoch
    cyc(0, 0, 0, 0, 0, 0, 1, "R10");
    cyc(1, 9, 1, 0, 0, 0, 0, "R10");
    for (int i = 0; i < 3000; i++) begin
      int pc, pf, fpc, tk;
      pc  = ($urandom % 4) + 64 * ($urandom % 8);
      pf  = $urandom % 2;
      fpc = ($urandom % 4) + 64 * ($urandom % 8);
      tk  = ($urandom % 25) == 0;
      cyc($urandom % 3 != 0, pc, pf, $urandom % 2, fpc, $urandom % 2, tk,
          tk ? "R10" : "R3");
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule